// File: doc/BRIEF.md
# Multi-cycle integer multiplier with high-half variants

This unit multiplies two 64-bit integer operands over several clock cycles and returns one 64-bit word of the product. The caller picks the word with an operation code. It can ask for the lower half of the product. It can ask for the upper half, with the operands read as signed/signed, signed/unsigned or unsigned/unsigned. It can also ask for a 32-bit product that is sign-extended to the full width.

Every operation uses one datapath. Each operand is first widened by one bit, either by sign extension or by zero extension, according to the signedness the operation asks for. A single radix-2 shift-add loop then forms the signed product of the two 65-bit values. On the last step the loop subtracts the partial product instead of adding it, because that step handles the sign bit of the second operand.

The caller raises `start_i` for one cycle with the operands and the operation code. `done_o` pulses when the result is ready. Only one request is in flight at a time.

Top module: `mul_unit`

## Requirements
- R1: After reset, `done_o` is 0 and `result_o` is 0.
- R2: Operation code 0 returns bits 63:0 of the product.
- R3: Operation code 1 returns bits 127:64 of the product with both operands read as two's-complement signed.
- R4: Operation code 2 returns bits 127:64 of the product with `a_i` read as signed and `b_i` read as unsigned.
- R5: Operation code 3 returns bits 127:64 of the product with both operands read as unsigned.
- R6: Operation code 4 multiplies `a_i[31:0]` by `b_i[31:0]`. It keeps bits 31:0 of that product and sign-extends bit 31 into bits 63:32 of the result.
- R7: Operation codes 5, 6 and 7 give the same result as code 0.
- R8: `done_o` is high for exactly one cycle. It rises 65 rising edges after the edge that accepted `start_i`.
- R9: A `start_i` pulse that arrives while a request is in flight is ignored. The in-flight request completes with its own operands and code, and no extra `done_o` pulse follows.
- R10: `result_o` changes only in the cycle that `done_o` rises, and it holds its value until the next completion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Request strobe; taken only when the unit is idle |
| op_i | input | 3 | Operation code (see R2 to R7) |
| a_i | input | 64 | First operand |
| b_i | input | 64 | Second operand |
| result_o | output | 64 | Selected product word, held between completions |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
The hardest case to reach from the ports is the final subtract step. That step only takes effect when the widened second operand is negative, so signed-high requests must carry a negative `b_i`. The extremes matter most: the most negative value paired with all ones, tried in both operand orders under every high variant. With those operands, a wrong widening of either operand changes the upper half of the product, where it can be seen. Random operands are also biased toward set sign bits. A second `start_i` pulse is also fired in the middle of a computation, to show that it is ignored.

// File: rtl/mul_pkg.sv
package mul_pkg;
  typedef enum logic [2:0] {
    MOP_LO   = 3'd0,
    MOP_HSS  = 3'd1,
    MOP_HSU  = 3'd2,
    MOP_HUU  = 3'd3,
    MOP_WORD = 3'd4
  } mop_e;

  function automatic logic op_a_signed(logic [2:0] op);
    return (op == MOP_HSS) || (op == MOP_HSU) || (op == MOP_WORD);
  endfunction

  function automatic logic op_b_signed(logic [2:0] op);
    return (op == MOP_HSS) || (op == MOP_WORD);
  endfunction
endpackage

// File: rtl/mul_opnd_ext.sv
module mul_opnd_ext
  import mul_pkg::*;
#(
  parameter int XLEN = 64,
  parameter int WLEN = 32,
  localparam int OW = XLEN + 1
) (
  input  logic [2:0]      op_i,
  input  logic [XLEN-1:0] a_i,
  input  logic [XLEN-1:0] b_i,
  output logic [OW-1:0]   a_x_o,
  output logic [OW-1:0]   b_x_o
);
  logic a_s, b_s;

  always_comb begin
    a_s = op_a_signed(op_i);
    b_s = op_b_signed(op_i);
    if (op_i == MOP_WORD) begin
      // only the low word of the product is kept, upper operand bits irrelevant
      a_x_o = {{(OW-WLEN){a_i[WLEN-1]}}, a_i[WLEN-1:0]};
      b_x_o = {{(OW-WLEN){b_i[WLEN-1]}}, b_i[WLEN-1:0]};
    end else begin
      a_x_o = {a_s & a_i[XLEN-1], a_i};
      b_x_o = {b_s & b_i[XLEN-1], b_i};
    end
  end
endmodule

// File: rtl/mul_shadd_core.sv
module mul_shadd_core #(
  parameter int OW = 65,
  localparam int PW = 2 * OW,
  localparam int CW = $clog2(OW + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [OW-1:0] a_i,
  input  logic [OW-1:0] b_i,
  output logic          busy_o,
  output logic          last_o,
  output logic [PW-1:0] prod_nxt_o
);
  logic [PW-1:0] acc_q, mc_q, addend;
  logic [OW-1:0] mp_q;
  logic [CW-1:0] cnt_q;
  logic          busy_q;

  assign busy_o = busy_q;
  assign last_o = busy_q && (cnt_q == CW'(OW - 1));

  always_comb begin
    addend = '0;
    if (mp_q[0]) addend = last_o ? (~mc_q + 1'b1) : mc_q; // sign bit has negative weight
    prod_nxt_o = acc_q + addend;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q  <= '0;
      mc_q   <= '0;
      mp_q   <= '0;
      cnt_q  <= '0;
      busy_q <= 1'b0;
    end else if (!busy_q) begin
      if (load_i) begin
        acc_q  <= '0;
        mc_q   <= {{OW{a_i[OW-1]}}, a_i};
        mp_q   <= b_i;
        cnt_q  <= '0;
        busy_q <= 1'b1;
      end
    end else begin
      acc_q <= prod_nxt_o;
      mc_q  <= {mc_q[PW-2:0], 1'b0};
      mp_q  <= {1'b0, mp_q[OW-1:1]};
      cnt_q <= cnt_q + 1'b1;
      if (last_o) busy_q <= 1'b0;
    end
  end
endmodule

// File: rtl/mul_res_sel.sv
module mul_res_sel
  import mul_pkg::*;
#(
  parameter int XLEN = 64,
  parameter int WLEN = 32,
  localparam int PW = 2 * (XLEN + 1)
) (
  input  logic [2:0]      op_i,
  input  logic [PW-1:0]   prod_i,
  output logic [XLEN-1:0] res_o
);
  always_comb begin
    unique case (op_i)
      MOP_HSS, MOP_HSU, MOP_HUU: res_o = prod_i[2*XLEN-1:XLEN];
      MOP_WORD: res_o = {{(XLEN-WLEN){prod_i[WLEN-1]}}, prod_i[WLEN-1:0]};
      default:  res_o = prod_i[XLEN-1:0];
    endcase
  end
endmodule

// File: rtl/mul_unit.sv
module mul_unit #(
  parameter int XLEN = 64,
  parameter int WLEN = 32,
  localparam int OW = XLEN + 1,
  localparam int PW = 2 * OW
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            start_i,
  input  logic [2:0]      op_i,
  input  logic [XLEN-1:0] a_i,
  input  logic [XLEN-1:0] b_i,
  output logic [XLEN-1:0] result_o,
  output logic            done_o
);
  logic [OW-1:0]   a_x, b_x;
  logic [PW-1:0]   prod_nxt;
  logic [XLEN-1:0] res_sel;
  logic [2:0]      op_q;
  logic            busy, last, accept;
  logic [XLEN-1:0] result_q;
  logic            done_q;

  assign accept = start_i && !busy;

  mul_opnd_ext #(.XLEN(XLEN), .WLEN(WLEN)) u_ext (
    .op_i (op_i),
    .a_i  (a_i),
    .b_i  (b_i),
    .a_x_o(a_x),
    .b_x_o(b_x)
  );

  mul_shadd_core #(.OW(OW)) u_core (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .load_i    (accept),
    .a_i       (a_x),
    .b_i       (b_x),
    .busy_o    (busy),
    .last_o    (last),
    .prod_nxt_o(prod_nxt)
  );

  mul_res_sel #(.XLEN(XLEN), .WLEN(WLEN)) u_sel (
    .op_i  (op_q),
    .prod_i(prod_nxt),
    .res_o (res_sel)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      op_q     <= '0;
      result_q <= '0;
      done_q   <= 1'b0;
    end else begin
      if (accept) op_q <= op_i;
      done_q <= last;
      if (last) result_q <= res_sel;
    end
  end

  assign result_o = result_q;
  assign done_o   = done_q;
endmodule

// File: rtl/mul_unit_chk.sv
module mul_unit_chk #(
  parameter int XLEN = 64,
  localparam int ITER = XLEN + 1,
  localparam int CW = $clog2(ITER + 2)
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            start_i,
  input logic [2:0]      op_i,
  input logic [XLEN-1:0] result_o,
  input logic            done_o
);
  logic          busy_c;
  logic [CW-1:0] cnt_c;
  logic [2:0]    op_c;
  logic          take;

  assign take = start_i && (!busy_c || done_o);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_c <= 1'b0;
      cnt_c  <= '0;
      op_c   <= '0;
    end else if (take) begin
      busy_c <= 1'b1;
      cnt_c  <= '0;
      op_c   <= op_i;
    end else if (busy_c) begin
      if (done_o) busy_c <= 1'b0;
      else cnt_c <= cnt_c + 1'b1;
    end
  end

  p_done_pulse_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  p_done_latency_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (busy_c && cnt_c == CW'(ITER)));

  p_no_stray_done_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_c |-> !done_o);

  p_hold_result_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_o |-> $stable(result_o));

  p_word_sext_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && op_c == 3'd4) |-> (result_o[XLEN-1:32] == {(XLEN-32){result_o[31]}}));
endmodule

bind mul_unit mul_unit_chk #(.XLEN(XLEN)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .start_i (start_i),
  .op_i    (op_i),
  .result_o(result_o),
  .done_o  (done_o)
);

// File: tb/tb_mul_unit.sv
module tb_mul_unit;
  localparam int CLK_P = 10;
  localparam int XLEN  = 64;
  localparam int LAT   = XLEN + 1;

  logic            clk_i = 1'b0;
  logic            rst_ni = 1'b0;
  logic            start_i = 1'b0;
  logic [2:0]      op_i = '0;
  logic [XLEN-1:0] a_i = '0, b_i = '0;
  logic [XLEN-1:0] result_o;
  logic            done_o;

  int checks = 0, errors = 0;
  bit finished = 0;

  mul_unit dut (.*);

  always #(CLK_P/2) clk_i = ~clk_i;

  function automatic logic [63:0] ref_mul(logic [2:0] op, logic [63:0] a, logic [63:0] b);
    logic signed [129:0] ae, be, p;
    logic [63:0] w;
    bit as, bs;
    if (op == 3'd4) begin
      w = a[31:0] * b[31:0];
      return {{32{w[31]}}, w[31:0]};
    end
    as = (op == 3'd1) || (op == 3'd2);
    bs = (op == 3'd1);
    ae = $signed({{66{as & a[63]}}, a});
    be = $signed({{66{bs & b[63]}}, b});
    p  = ae * be;
    if (op >= 3'd1 && op <= 3'd3) return p[127:64];
    return p[63:0];
  endfunction

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // issue a request, wait for done, check result and latency
  task automatic run(string req, logic [2:0] op, logic [63:0] a, logic [63:0] b);
    int n = 0;
    @(negedge clk_i);
    start_i = 1'b1; op_i = op; a_i = a; b_i = b;
    @(negedge clk_i);
    start_i = 1'b0; a_i = ~a; b_i = ~b; op_i = ~op;
    while (!done_o && n < 200) begin
      @(negedge clk_i);
      n++;
    end
    check({req, " result"}, result_o, ref_mul(op, a, b));
    check("R8 latency", 64'(n), 64'(LAT));
    @(negedge clk_i);
    check("R8 single-cycle done", {63'b0, done_o}, 64'd0);
  endtask

  initial begin
    #(CLK_P * 200000);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [63:0] mn, ones, ra, rb, held;
    void'($urandom(32'd1234));
    mn = 64'h8000_0000_0000_0000;
    ones = '1;
    repeat (3) @(negedge clk_i);
    check("R1 done", {63'b0, done_o}, 64'd0);
    check("R1 result", result_o, 64'd0);
    rst_ni = 1'b1;

    run("R2", 3'd0, 64'd7, 64'd9);
    run("R2", 3'd0, mn, ones);
    run("R3", 3'd1, mn, ones);
    run("R3", 3'd1, ones, mn);
    run("R3", 3'd1, mn, mn);
    run("R4", 3'd2, mn, ones);
    run("R4", 3'd2, ones, mn);
    run("R4", 3'd2, ones, ones);
    run("R5", 3'd3, mn, ones);
    run("R5", 3'd3, ones, mn);
    run("R5", 3'd3, ones, ones);
    run("R6", 3'd4, 64'hFFFF_FFFF_0001_0000, 64'h1234_5678_0000_8000);
    run("R6", 3'd4, 64'd3, 64'hFFFF_FFFF_FFFF_FFFF);
    run("R7", 3'd5, mn, ones);
    run("R7", 3'd6, 64'h1234_5678_9ABC_DEF0, 64'hFEDC_BA98_7654_3210);
    run("R7", 3'd7, 64'hDEAD_BEEF_0000_0001, 64'h0000_0001_0000_0003);

    // R9: start in flight ignored
    begin
      int n = 0;
      @(negedge clk_i);
      start_i = 1'b1; op_i = 3'd1; a_i = mn; b_i = 64'd5;
      @(negedge clk_i);
      start_i = 1'b0;
      repeat (10) @(negedge clk_i);
      start_i = 1'b1; op_i = 3'd0; a_i = 64'd11; b_i = 64'd13;
      @(negedge clk_i);
      start_i = 1'b0;
      n = 11;
      while (!done_o && n < 200) begin
        @(negedge clk_i);
        n++;
      end
      check("R9 first result kept", result_o, ref_mul(3'd1, mn, 64'd5));
      check("R9 latency unchanged", 64'(n), 64'(LAT));
      held = result_o;
      repeat (80) begin
        @(negedge clk_i);
        if (done_o) check("R9 no extra done", 64'd1, 64'd0);
      end
      check("R10 result held", result_o, held);
    end

    for (int i = 0; i < 40; i++) begin
      logic [2:0] op;
      ra = {$urandom, $urandom};
      rb = {$urandom, $urandom};
      if (i % 3 == 0) ra[63] = 1'b1;
      if (i % 4 == 0) rb[63] = 1'b1;
      op = 3'($urandom_range(0, 7));
      run(op == 3'd0 ? "R2" : op == 3'd1 ? "R3" : op == 3'd2 ? "R4" :
          op == 3'd3 ? "R5" : op == 3'd4 ? "R6" : "R7", op, ra, rb);
      held = result_o;
      @(negedge clk_i);
      check("R10 hold", result_o, held);
    end

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule